// File: doc/BRIEF.md
# SMBus Byte-Paced Block Transfer Host

This block is the per-byte block engine of an SMBus host controller. It runs block writes, SMBus block reads and I2C-style block reads. Every data byte passes through one block data register, and software paces the transfer with a handshake flag. Software programs the slave address, the command byte, the count and the first byte. It then writes the control register with a start bit. The host produces a sequence of byte-level bus operations: start, repeated start, write byte, read byte (with the host's acknowledge choice) and stop. A bus engine further down the chain carries out each operation and pulses a completion strobe. Bit-level SCL/SDA timing belongs to that engine and is not part of this block.

After each data byte the host raises a byte-done flag and holds the bus. While the flag is set it issues no further operation. Software clears the flag by writing a 1 to it. On a write, software loads the next byte first. On a read, it takes the current byte first. To end a read, software rewrites the control register with a last-byte encoding. The host then answers the next byte it reads with a NACK, and it closes the transfer once that byte's flag is cleared. An SMBus block read takes its length from the first received byte. An I2C block read has no count byte and takes its command byte from the data1 register.

Top module: `smbus_bytewise_host`

## Requirements
- R1: After reset, every register reads 0x00 and no bus operation is requested (bus_op_valid low).
- R2: A write to control (offset 1) with bit 6 (start) set and encoding bits [5:2] equal to 0x14 or 0x18 (0x34/0x38 also accepted) starts a transfer, but only while idle. Busy (status bit 0) rises and the first operation is a start (op code 1). A start with any other encoding, or any control write while busy, issues no new start condition. A write while busy still updates the stored encoding.
- R3: A block write has encoding 0x14 and address register (offset 3) bit 0 = 0. It issues, in order: start, write of the address with bit 0 cleared, write of the command register (offset 2), write of the count from data0 (offset 4), then count writes, each taking the block data register (offset 6) as it stands when the write is issued, then stop (op code 5). Write op code is 3.
- R4: After each data byte completes, status bit 7 (byte done) is set. No bus operation is requested until software writes status (offset 0) with bit 7 = 1. A status write with bit 7 = 0 leaves the flag set.
- R5: An SMBus block read has encoding 0x14/0x34 and address bit 0 = 1. It issues start, the address with bit 0 = 0, the command register, a repeated start (op code 2), and the address with bit 0 = 1. It then reads the count byte (op code 4, acknowledged), which is stored in data0 and raises no byte done. Each data byte after that is stored in block data.
- R6: An I2C block read (encoding 0x18/0x38) sends data1 (offset 5) as its command byte, not the command register. It reads no count byte: the first read after the repeated-start address is a data byte.
- R7: A read byte that completes while the control encoding has bit 5 set (0x34 or 0x38) is NACKed (bus_ack low). All other reads are acknowledged. Once that byte's flag is cleared, the host issues a stop and busy falls.
- R8: A received SMBus count of 0 or above 32 is stored in data0 and raises byte done with no data byte read. The first clear of byte done leads to a stop, and busy falls.
- R9: When the final stop completes, busy falls and status bit 1 (complete) is set. Writing status with bit 1 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr (combinational) |
| bus_op_valid | output | 1 | A bus operation is requested; held until bus_op_done |
| bus_op | output | 3 | Operation: 1 start, 2 repeated start, 3 write, 4 read, 5 stop |
| bus_wdata | output | 8 | Byte to send for a write operation |
| bus_ack | output | 1 | For a read: 1 acknowledge, 0 NACK |
| bus_op_done | input | 1 | One-cycle pulse: the requested operation has finished |
| bus_rdata | input | 8 | Byte received, valid with bus_op_done of a read |

## Verification
A corrupted sequencing state shows up at the bus side on the very next requested operation, as a wrong op code or a wrong byte. The first place to look is the address read/write bit and the source of the command byte. A missed or spurious byte-done flag shows up within one bus operation. Either an operation is requested while the flag is set, or the host stalls and busy never falls. A wrong acknowledge choice is visible on bus_ack at the completion of the final read. A count-handling error shows as data reads after a bad count, or as a missing stop once the flag is cleared.

// File: rtl/smbus_bytewise_host.sv
module smbus_bytewise_host #(
  parameter int MAX_BLOCK = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bus_op_valid,
  output logic [2:0] bus_op,
  output logic [7:0] bus_wdata,
  output logic       bus_ack,
  input  logic       bus_op_done,
  input  logic [7:0] bus_rdata
);

  localparam logic [7:0] MAXB      = 8'(MAX_BLOCK);
  localparam logic [2:0] OP_START  = 3'd1;
  localparam logic [2:0] OP_RSTART = 3'd2;
  localparam logic [2:0] OP_WRITE  = 3'd3;
  localparam logic [2:0] OP_READ   = 3'd4;
  localparam logic [2:0] OP_STOP   = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_WADDR, ST_CMD, ST_RSTART,
    ST_RADDR, ST_COUNT, ST_DATA, ST_HOLD, ST_STOP
  } st_t;

  st_t        state;
  logic [7:0] ctrl_q, cmd_q, addr_q, dat0_q, dat1_q, blk_q, left_q;
  logic       byte_done_q, cmpl_q, fin_q, mode_rd_q, mode_i2c_q;

  wire busy      = (state != ST_IDLE);
  wire wr_stat   = reg_we && reg_addr == 3'd0;
  wire wr_ctrl   = reg_we && reg_addr == 3'd1;
  wire enc_ok    = (reg_wdata[4:2] == 3'b101) || (reg_wdata[4:2] == 3'b110);
  wire start_go  = wr_ctrl && reg_wdata[6] && enc_ok && !busy;
  wire clr_bd    = wr_stat && reg_wdata[7] && byte_done_q;
  wire bad_count = (bus_rdata == 8'd0) || (bus_rdata > MAXB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ctrl_q      <= '0;
      cmd_q       <= '0;
      addr_q      <= '0;
      dat0_q      <= '0;
      dat1_q      <= '0;
      blk_q       <= '0;
      left_q      <= '0;
      byte_done_q <= 1'b0;
      cmpl_q      <= 1'b0;
      fin_q       <= 1'b0;
      mode_rd_q   <= 1'b0;
      mode_i2c_q  <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd1: ctrl_q <= reg_wdata & 8'hBF;
          3'd2: cmd_q  <= reg_wdata;
          3'd3: addr_q <= reg_wdata;
          3'd4: dat0_q <= reg_wdata;
          3'd5: dat1_q <= reg_wdata;
          3'd6: blk_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_stat && reg_wdata[1]) cmpl_q <= 1'b0;

      case (state)
        ST_IDLE: if (start_go) begin
          state       <= ST_START;
          byte_done_q <= 1'b0;
          fin_q       <= 1'b0;
          mode_i2c_q  <= reg_wdata[3];
          mode_rd_q   <= reg_wdata[3] | addr_q[0];
        end
        ST_START:  if (bus_op_done) state <= ST_WADDR;
        ST_WADDR:  if (bus_op_done) state <= ST_CMD;
        ST_CMD:    if (bus_op_done) state <= mode_rd_q ? ST_RSTART : ST_COUNT;
        ST_RSTART: if (bus_op_done) state <= ST_RADDR;
        ST_RADDR:  if (bus_op_done) state <= mode_i2c_q ? ST_DATA : ST_COUNT;
        ST_COUNT: if (bus_op_done) begin
          if (mode_rd_q) begin
            dat0_q <= bus_rdata;
            if (bad_count) begin
              byte_done_q <= 1'b1;
              fin_q       <= 1'b1;
              state       <= ST_HOLD;
            end else begin
              state <= ST_DATA;
            end
          end else begin
            left_q <= dat0_q;
            state  <= (dat0_q == 8'd0) ? ST_STOP : ST_DATA;
          end
        end
        ST_DATA: if (bus_op_done) begin
          byte_done_q <= 1'b1;
          state       <= ST_HOLD;
          if (mode_rd_q) begin
            blk_q <= bus_rdata;
            fin_q <= ctrl_q[5];
          end else begin
            left_q <= left_q - 8'd1;
            fin_q  <= (left_q == 8'd1);
          end
        end
        ST_HOLD: if (clr_bd) begin
          byte_done_q <= 1'b0;
          state       <= fin_q ? ST_STOP : ST_DATA;
        end
        ST_STOP: if (bus_op_done) begin
          cmpl_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_op_valid = 1'b1;
    bus_op       = OP_WRITE;
    bus_wdata    = 8'h00;
    case (state)
      ST_START:  bus_op = OP_START;
      ST_WADDR:  bus_wdata = {addr_q[7:1], 1'b0};
      ST_CMD:    bus_wdata = mode_i2c_q ? dat1_q : cmd_q;
      ST_RSTART: bus_op = OP_RSTART;
      ST_RADDR:  bus_wdata = {addr_q[7:1], 1'b1};
      ST_COUNT: begin
        bus_op    = mode_rd_q ? OP_READ : OP_WRITE;
        bus_wdata = dat0_q;
      end
      ST_DATA: begin
        bus_op    = mode_rd_q ? OP_READ : OP_WRITE;
        bus_wdata = blk_q;
      end
      ST_STOP: bus_op = OP_STOP;
      default: begin
        bus_op_valid = 1'b0;
        bus_op       = 3'd0;
      end
    endcase
  end

  assign bus_ack = !(state == ST_DATA && mode_rd_q && ctrl_q[5]);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {byte_done_q, 5'b0, cmpl_q, busy};
      3'd1:    reg_rdata = ctrl_q;
      3'd2:    reg_rdata = cmd_q;
      3'd3:    reg_rdata = addr_q;
      3'd4:    reg_rdata = dat0_q;
      3'd5:    reg_rdata = dat1_q;
      3'd6:    reg_rdata = blk_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r4_hold_bus: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_q |-> !bus_op_valid);

  a_r4_flag_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_q |-> busy);

  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_op_valid && bus_op == OP_START));

  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op_valid && bus_op == OP_START && $past(busy)) |-> $past(bus_op == OP_START));

  a_r2_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op_valid && !bus_op_done) |=> (bus_op_valid && $stable(bus_op)));

  a_r7_nack_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op_valid && bus_op == OP_READ && bus_op_done && !bus_ack) |=> (byte_done_q && !bus_op_valid));

  a_r9_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bus_op_valid && bus_op == OP_STOP && bus_op_done));

  a_r9_complete_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cmpl_q);

endmodule

// File: tb/smbus_bytewise_host_tb.sv
`timescale 1ns/1ps
module smbus_bytewise_host_tb;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_op_valid, bus_ack;
  logic [2:0] bus_op;
  logic [7:0] bus_wdata;
  logic bus_op_done = 0;
  logic [7:0] bus_rdata = 0;

  smbus_bytewise_host u_dut (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [2:0] lg_op [0:127];
  logic [7:0] lg_d  [0:127];
  logic       lg_a  [0:127];
  int lg_n = 0;
  logic [2:0] ex_op [0:127];
  logic [7:0] ex_d  [0:127];
  logic       ex_a  [0:127];
  int ex_n = 0;
  logic [7:0] rd_mem [0:63];
  int rd_idx = 0;
  int wait_cnt = 0;

  always @(negedge clk) begin
    if (bus_op_done) bus_op_done = 0;
    else if (bus_op_valid) begin
      if (wait_cnt == 0) begin
        if (bus_op == 3'd4) begin
          bus_rdata = rd_mem[rd_idx];
          rd_idx++;
        end
        if (lg_n < 128) begin
          lg_op[lg_n] = bus_op; lg_d[lg_n] = bus_wdata; lg_a[lg_n] = bus_ack;
        end
        lg_n++;
        bus_op_done = 1;
        wait_cnt = $urandom % 3;
      end else wait_cnt--;
    end
  end

  task automatic chk(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_bd(string r);
    logic [7:0] s;
    for (int k = 0; k < 400; k++) begin
      rd(3'd0, s);
      if (s[7]) return;
    end
    chk(r, 0, 1);
  endtask

  task automatic wait_idle(string r);
    logic [7:0] s;
    for (int k = 0; k < 400; k++) begin
      rd(3'd0, s);
      if (!s[0]) return;
    end
    chk(r, 1, 0);
  endtask

  task automatic ex(input logic [2:0] o, input logic [7:0] d, input logic a);
    ex_op[ex_n] = o; ex_d[ex_n] = d; ex_a[ex_n] = a; ex_n++;
  endtask

  task automatic clear_logs();
    lg_n = 0; ex_n = 0; rd_idx = 0;
  endtask

  task automatic cmp_log(string r);
    chk({r, " op count"}, lg_n, ex_n);
    for (int k = 0; k < ex_n && k < lg_n; k++) begin
      chk({r, " op"}, lg_op[k], ex_op[k]);
      if (ex_op[k] == 3'd3) chk({r, " wdata"}, lg_d[k], ex_d[k]);
      if (ex_op[k] == 3'd4) chk({r, " ack"}, lg_a[k], ex_a[k]);
    end
  endtask

  task automatic check_complete(string r);
    logic [7:0] s;
    rd(3'd0, s);
    chk({r, " complete flag R9"}, s, 8'h02);
    wr(3'd0, 8'h02);
    rd(3'd0, s);
    chk("R9 complete cleared", s, 8'h00);
  endtask

  task automatic do_write(int len, bit poke);
    logic [7:0] a, c, s;
    logic [7:0] b [0:31];
    int n0;
    clear_logs();
    a = {7'($urandom), 1'b0}; c = 8'($urandom);
    for (int i = 0; i < len; i++) b[i] = 8'($urandom);
    ex(1, 0, 1); ex(3, a, 1); ex(3, c, 1); ex(3, 8'(len), 1);
    for (int i = 0; i < len; i++) ex(3, b[i], 1);
    ex(5, 0, 1);
    wr(3'd3, a); wr(3'd2, c); wr(3'd4, 8'(len)); wr(3'd6, b[0]);
    wr(3'd1, 8'h54);
    for (int i = 0; i < len; i++) begin
      wait_bd("R4 byte done on write");
      if (i == 0) begin
        n0 = lg_n;
        repeat (6) @(negedge clk);
        chk("R4 bus held while byte done", lg_n, n0);
        chk("R4 no op valid in hold", bus_op_valid, 0);
        wr(3'd0, 8'h00);
        rd(3'd0, s);
        chk("R4 zero write keeps flag", s[7], 1);
        if (poke) begin
          wr(3'd1, 8'h54);
          repeat (4) @(negedge clk);
          chk("R2 start while busy ignored", lg_n, n0);
        end
      end
      if (i + 1 < len) wr(3'd6, b[i+1]);
      wr(3'd0, 8'h80);
    end
    wait_idle("R3 write completes");
    cmp_log("R3 block write");
    check_complete("R3");
  endtask

  task automatic do_read(int len, bit i2c);
    logic [7:0] a, c, d1, s;
    clear_logs();
    a = {7'($urandom), 1'b1}; c = 8'($urandom); d1 = 8'($urandom);
    if (i2c) a[0] = 0;
    if (!i2c) rd_mem[0] = 8'(len);
    for (int i = 0; i < len; i++) rd_mem[i + (i2c ? 0 : 1)] = 8'($urandom);
    ex(1, 0, 1); ex(3, {a[7:1], 1'b0}, 1);
    ex(3, i2c ? d1 : c, 1);
    ex(2, 0, 1); ex(3, {a[7:1], 1'b1}, 1);
    if (!i2c) ex(4, 0, 1);
    for (int i = 0; i < len; i++) ex(4, 0, i != len - 1);
    ex(5, 0, 1);
    wr(3'd3, a); wr(3'd2, c); wr(3'd5, d1);
    wr(3'd1, (i2c ? 8'h18 : 8'h14) | (len == 1 ? 8'h20 : 8'h00) | 8'h40);
    for (int i = 0; i < len; i++) begin
      wait_bd(i2c ? "R6 byte done" : "R5 byte done");
      if (i == 0 && !i2c) begin
        rd(3'd4, s);
        chk("R5 count in data0", s, len);
      end
      rd(3'd6, s);
      chk(i2c ? "R6 data byte" : "R5 data byte", s, rd_mem[i + (i2c ? 0 : 1)]);
      if (i + 2 == len) wr(3'd1, i2c ? 8'h38 : 8'h34);
      wr(3'd0, 8'h80);
    end
    wait_idle("R7 read completes");
    cmp_log(i2c ? "R6/R7 i2c read" : "R5/R7 smbus read");
    check_complete(i2c ? "R6" : "R5");
  endtask

  task automatic do_bad(logic [7:0] cnt);
    logic [7:0] a, s;
    int k;
    clear_logs();
    a = {7'($urandom), 1'b1};
    rd_mem[0] = cnt; rd_mem[1] = 8'h5A;
    ex(1, 0, 1); ex(3, {a[7:1], 1'b0}, 1); ex(3, 8'h11, 1);
    ex(2, 0, 1); ex(3, a, 1); ex(4, 0, 1); ex(5, 0, 1);
    wr(3'd3, a); wr(3'd2, 8'h11); wr(3'd1, 8'h54);
    wait_bd("R8 byte done on bad count");
    rd(3'd4, s);
    chk("R8 bad count in data0", s, cnt);
    k = 0;
    do begin
      wr(3'd0, 8'h80);
      repeat (8) @(negedge clk);
      rd(3'd0, s);
      k++;
    end while (s[0] && k < 40);
    chk("R8 busy falls after one clear", k, 1);
    cmp_log("R8 bad count");
    check_complete("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    void'($urandom(32'hC0FFEE));
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < 7; r++) begin
      rd(3'(r), s);
      chk("R1 reset register", s, 0);
    end
    chk("R1 no bus op at reset", bus_op_valid, 0);

    clear_logs();
    wr(3'd1, 8'h48);
    repeat (6) @(negedge clk);
    rd(3'd0, s);
    chk("R2 bad encoding no busy", s[0], 0);
    chk("R2 bad encoding no op", lg_n, 0);

    do_write(1, 0);
    do_write(32, 1);
    do_read(1, 0);
    do_read(32, 0);
    do_read(1, 1);
    do_read(32, 1);
    do_bad(8'd0);
    do_bad(8'd33);
    for (int t = 0; t < 6; t++) begin
      do_write(1 + $urandom % 32, t[0]);
      do_read(1 + $urandom % 32, 0);
      do_read(1 + $urandom % 32, 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule